// File: doc/BRIEF.md
# Frequency-Domain Pilot Equaliser with Walsh Despreading

This block sits on the receive side of a multicarrier spread-spectrum link, after the FFT. It takes one complex value per used subcarrier per cycle. Each frame starts with one pilot symbol. The block turns each pilot value into a per-subcarrier equalisation coefficient and keeps that coefficient for every data symbol until the next pilot arrives. Each data subcarrier value is multiplied by its stored coefficient. Groups of `NU` consecutive equalised values are then combined with one user's Walsh-Hadamard code, which recovers that user's `NSC/NU` symbols per multicarrier symbol.

Four single-user combining rules are available. The rule is chosen while the pilot is being received, because it fixes how each coefficient is derived from the channel value. The regularised rule uses a constant noise term that stands for a 12 dB signal-to-noise ratio. The term is not measured. Samples are Q(FRAC) fixed point, so the value 2^FRAC represents one. Every pilot symbol is assumed to have been sent as 1+0j, so the received pilot value is the channel value H.

Top module: `pilot_eq_despread`

## Requirements
- R1: After reset, `out_valid` is 0, `out_re`/`out_im`/`out_idx` are 0, the subcarrier position is 0 and every stored coefficient is 0, so data sent before any pilot despreads to 0.
- R2: Each cycle with `in_valid`=1 consumes the next subcarrier position k, counting 0..NSC-1 and wrapping to 0. Cycles with `in_valid`=0 change nothing, whatever the other inputs are.
- R3: A pilot sample (`in_valid`=1, `in_pilot`=1) with `in_mode`=0 stores W(k) = conj(H) = (Hr, -Hi).
- R4: With `in_mode`=1, W = (Hr·2^FRAC/D, -Hi·2^FRAC/D). Here D = max(|Hr|,|Hi|) + floor(min(|Hr|,|Hi|)/2), and the divisions truncate toward zero.
- R5: With `in_mode`=2, the same form is used with D = floor((Hr²+Hi²)/2^FRAC).
- R6: With `in_mode`=3, the same form is used with D = floor((Hr²+Hi²)/2^FRAC) + NOISE, where NOISE defaults to 16 (about 2^FRAC·10^-1.2). A D of 0 in any mode is replaced by 1.
- R7: Each coefficient part is saturated to the signed CW-bit range [-2^(CW-1), 2^(CW-1)-1].
- R8: Stored coefficients are reused unchanged for every data symbol until a new pilot overwrites them. `in_mode` has no effect on data samples.
- R9: A data sample Y at position k is equalised to E = floor((Y·W(k)) / 2^FRAC), using the full complex product.
- R10: Chip c = k mod NU belongs to output index g = floor(k/NU). It is negated when the parity of (`in_user` AND c) is odd. In the cycle after chip NU-1, `out_valid` is 1 for one cycle, `out_idx`=g, and the output equals floor(sum of signed E / NU).
- R11: Pilot samples never produce an output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present this cycle |
| in_pilot | input | 1 | Sample belongs to the pilot symbol |
| in_mode | input | 2 | Combining rule: 0 MRC, 1 EGC, 2 ORC, 3 MMSE |
| in_user | input | log2(NU) | Walsh code row of the user to recover |
| in_re | input | DW | Subcarrier value, real part |
| in_im | input | DW | Subcarrier value, imaginary part |
| out_valid | output | 1 | Despread symbol present |
| out_idx | output | log2(NSC/NU) | Symbol index within the multicarrier symbol |
| out_re | output | DW+CW-FRAC+1 | Despread symbol, real part |
| out_im | output | DW+CW-FRAC+1 | Despread symbol, imaginary part |

## Verification
The embedded properties check the following on every cycle: the subcarrier position stays in range and holds through idle cycles, a pilot write lands at its address, output pulses come only after a final data chip and are never back to back, pilots raise no pulse, and a coefficient never takes the opposite sign to the channel's real part. Only the bench scenarios can confirm the numeric values. These are the four coefficient formulas, saturation, the parity-based chip signs for different users, and the floor scaling. The bench scenarios also cover the fact that a frame's coefficients survive idle gaps, mode toggling and a second data symbol.

// File: rtl/mceq_pkg.sv
package mceq_pkg;
    typedef enum logic [1:0] {
        CMB_MRC  = 2'd0,
        CMB_EGC  = 2'd1,
        CMB_ORC  = 2'd2,
        CMB_MMSE = 2'd3
    } comb_mode_e;
endpackage

// File: rtl/mceq_coef_calc.sv
// Derives one equalisation coefficient from a pilot channel value.
module mceq_coef_calc
    import mceq_pkg::*;
#(
    parameter int DW    = 10,
    parameter int FRAC  = 8,
    parameter int CW    = 13,
    parameter int NOISE = 16
) (
    input  comb_mode_e               mode,
    input  logic signed [DW-1:0]     h_re,
    input  logic signed [DW-1:0]     h_im,
    output logic signed [CW-1:0]     w_re,
    output logic signed [CW-1:0]     w_im
);
    localparam int QW = 2*DW + FRAC + 2;
    localparam logic signed [QW-1:0] CMAX = QW'((64'sd1 <<< (CW-1)) - 64'sd1);
    localparam logic signed [QW-1:0] CMIN = QW'(-(64'sd1 <<< (CW-1)));

    function automatic logic signed [CW-1:0] clip(input logic signed [QW-1:0] v);
        if (v > CMAX) return CMAX[CW-1:0];
        if (v < CMIN) return CMIN[CW-1:0];
        return v[CW-1:0];
    endfunction

    logic signed [QW-1:0] hr, hi, ar, ai, mx, mn, mag, pw, den, q_re, q_im;

    always_comb begin
        hr  = QW'(h_re);
        hi  = QW'(h_im);
        ar  = (hr < 0) ? -hr : hr;
        ai  = (hi < 0) ? -hi : hi;
        mx  = (ar > ai) ? ar : ai;
        mn  = (ar > ai) ? ai : ar;
        mag = mx + (mn >>> 1);
        pw  = (hr*hr + hi*hi) >>> FRAC;
        case (mode)
            CMB_EGC:  den = mag;
            CMB_ORC:  den = pw;
            CMB_MMSE: den = pw + QW'(NOISE);
            default:  den = QW'(1) <<< FRAC;   // unity gain leaves conj(H)
        endcase
        if (den == '0) den = QW'(1);
        q_re = (hr <<< FRAC) / den;
        q_im = ((-hi) <<< FRAC) / den;
        w_re = clip(q_re);
        w_im = clip(q_im);
    end
endmodule

// File: rtl/mceq_coef_store.sv
// Per-subcarrier coefficient memory, written by pilot samples.
module mceq_coef_store #(
    parameter int NSC = 48,
    parameter int CW  = 13,
    parameter int AW  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic signed [CW-1:0] wr_re,
    input  logic signed [CW-1:0] wr_im,
    input  logic [AW-1:0]        rd_addr,
    output logic signed [CW-1:0] rd_re,
    output logic signed [CW-1:0] rd_im
);
    logic signed [CW-1:0] re_q [NSC];
    logic signed [CW-1:0] im_q [NSC];
    logic signed [CW-1:0] re_d [NSC];
    logic signed [CW-1:0] im_d [NSC];

    always_comb begin
        re_d = re_q;
        im_d = im_q;
        if (wr_en) begin
            re_d[wr_addr] = wr_re;
            im_d[wr_addr] = wr_im;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSC; i++) begin
                re_q[i] <= '0;
                im_q[i] <= '0;
            end
        end else begin
            re_q <= re_d;
            im_q <= im_d;
        end
    end

    assign rd_re = re_q[rd_addr];
    assign rd_im = im_q[rd_addr];

    // R8: a pilot write is present at its address on the next cycle
    a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (re_q[$past(wr_addr)] == $past(wr_re)) && (im_q[$past(wr_addr)] == $past(wr_im)));
endmodule

// File: rtl/mceq_cmul.sv
// Complex multiply of a subcarrier value by its coefficient, scaled back by 2^FRAC.
module mceq_cmul #(
    parameter int DW   = 10,
    parameter int CW   = 13,
    parameter int FRAC = 8,
    parameter int EW   = DW + CW - FRAC + 1
) (
    input  logic signed [DW-1:0] y_re,
    input  logic signed [DW-1:0] y_im,
    input  logic signed [CW-1:0] w_re,
    input  logic signed [CW-1:0] w_im,
    output logic signed [EW-1:0] e_re,
    output logic signed [EW-1:0] e_im
);
    localparam int PW = DW + CW + 1;
    logic signed [PW-1:0] sr, si;

    always_comb begin
        sr   = PW'(y_re) * PW'(w_re) - PW'(y_im) * PW'(w_im);
        si   = PW'(y_re) * PW'(w_im) + PW'(y_im) * PW'(w_re);
        e_re = EW'(sr >>> FRAC);
        e_im = EW'(si >>> FRAC);
    end
endmodule

// File: rtl/mceq_despread.sv
// Walsh-Hadamard despreading of NU consecutive equalised chips.
module mceq_despread #(
    parameter int NU  = 8,
    parameter int NB  = 6,
    parameter int EW  = 16,
    parameter int LNU = $clog2(NU),
    parameter int GW  = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid,
    input  logic [LNU-1:0]       chip,
    input  logic [GW-1:0]        group,
    input  logic [LNU-1:0]       user,
    input  logic signed [EW-1:0] e_re,
    input  logic signed [EW-1:0] e_im,
    output logic                 out_valid,
    output logic [GW-1:0]        out_idx,
    output logic signed [EW-1:0] out_re,
    output logic signed [EW-1:0] out_im
);
    localparam int AW = EW + LNU;

    typedef struct packed {
        logic signed [AW-1:0] acc_re;
        logic signed [AW-1:0] acc_im;
        logic                 ov;
        logic [GW-1:0]        oidx;
        logic signed [EW-1:0] ore;
        logic signed [EW-1:0] oim;
    } ds_state_t;

    ds_state_t st_d, st_q;
    logic signed [AW-1:0] t_re, t_im, b_re, b_im, s_re, s_im;
    logic neg;

    always_comb begin
        st_d    = st_q;
        st_d.ov = 1'b0;
        neg     = ^(user & chip);
        t_re    = neg ? -AW'(e_re) : AW'(e_re);
        t_im    = neg ? -AW'(e_im) : AW'(e_im);
        b_re    = (chip == LNU'(0)) ? '0 : st_q.acc_re;
        b_im    = (chip == LNU'(0)) ? '0 : st_q.acc_im;
        s_re    = b_re + t_re;
        s_im    = b_im + t_im;
        if (valid) begin
            st_d.acc_re = s_re;
            st_d.acc_im = s_im;
            if (chip == LNU'(NU-1)) begin
                st_d.ov   = 1'b1;
                st_d.oidx = group;
                st_d.ore  = EW'(s_re >>> LNU);
                st_d.oim  = EW'(s_im >>> LNU);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.ov;
    assign out_idx   = st_q.oidx;
    assign out_re    = st_q.ore;
    assign out_im    = st_q.oim;

    // R10: a pulse follows only a final chip of a data group
    a_r10_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(valid && (chip == LNU'(NU-1))));
    // R10: the symbol index stays inside the symbol
    a_r10_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_idx) < NB));
    // R10: a pulse lasts one cycle
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
endmodule

// File: rtl/pilot_eq_despread.sv
module pilot_eq_despread
    import mceq_pkg::*;
#(
    parameter int DW    = 10,
    parameter int FRAC  = 8,
    parameter int CW    = 13,
    parameter int NSC   = 48,
    parameter int NU    = 8,
    parameter int NOISE = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic                              in_pilot,
    input  logic [1:0]                        in_mode,
    input  logic [$clog2(NU)-1:0]             in_user,
    input  logic signed [DW-1:0]              in_re,
    input  logic signed [DW-1:0]              in_im,
    output logic                              out_valid,
    output logic [((NSC/NU > 1) ? $clog2(NSC/NU) : 1)-1:0] out_idx,
    output logic signed [DW+CW-FRAC:0]        out_re,
    output logic signed [DW+CW-FRAC:0]        out_im
);
    localparam int LNU = $clog2(NU);
    localparam int NB  = NSC / NU;
    localparam int GW  = (NB > 1) ? $clog2(NB) : 1;
    localparam int AW  = $clog2(NSC);
    localparam int EW  = DW + CW - FRAC + 1;

    typedef struct packed {
        logic [AW-1:0] sc;
    } top_state_t;

    top_state_t st_d, st_q;
    logic signed [CW-1:0] cw_re, cw_im, rd_re, rd_im;
    logic signed [EW-1:0] e_re, e_im;
    logic                 pil_wr, dat_ok;

    always_comb begin
        st_d   = st_q;
        pil_wr = in_valid && in_pilot;
        dat_ok = in_valid && !in_pilot;
        if (in_valid)
            st_d.sc = (st_q.sc == AW'(NSC-1)) ? '0 : st_q.sc + AW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    mceq_coef_calc #(.DW(DW), .FRAC(FRAC), .CW(CW), .NOISE(NOISE)) u_calc (
        .mode (comb_mode_e'(in_mode)),
        .h_re (in_re),
        .h_im (in_im),
        .w_re (cw_re),
        .w_im (cw_im)
    );

    mceq_coef_store #(.NSC(NSC), .CW(CW), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pil_wr),
        .wr_addr (st_q.sc),
        .wr_re   (cw_re),
        .wr_im   (cw_im),
        .rd_addr (st_q.sc),
        .rd_re   (rd_re),
        .rd_im   (rd_im)
    );

    mceq_cmul #(.DW(DW), .CW(CW), .FRAC(FRAC), .EW(EW)) u_mul (
        .y_re (in_re),
        .y_im (in_im),
        .w_re (rd_re),
        .w_im (rd_im),
        .e_re (e_re),
        .e_im (e_im)
    );

    mceq_despread #(.NU(NU), .NB(NB), .EW(EW), .LNU(LNU), .GW(GW)) u_desp (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (dat_ok),
        .chip      (st_q.sc[LNU-1:0]),
        .group     (GW'(st_q.sc >> LNU)),
        .user      (in_user),
        .e_re      (e_re),
        .e_im      (e_im),
        .out_valid (out_valid),
        .out_idx   (out_idx),
        .out_re    (out_re),
        .out_im    (out_im)
    );

    // R2: position stays within the used subcarriers
    a_r2_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.sc) < NSC);
    // R2: idle cycles leave the position alone
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q.sc));
    // R11: a pilot sample is never followed by an output pulse
    a_r11_pilot_silent: assert property (@(posedge clk) disable iff (!rst_n)
        pil_wr |=> !out_valid);
    // R4, R5, R6: normalising rules keep the sign of the channel's real part
    a_r5_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (pil_wr && (in_mode != 2'd0) && (in_re > 0)) |-> (cw_re >= 0));
endmodule

// File: tb/pilot_eq_despread_tb.sv
`timescale 1ns/1ps
module pilot_eq_despread_tb;
    localparam int DW = 10, FRAC = 8, CW = 13, NSC = 48, NU = 8, NOISE = 16;
    localparam int NB = NSC / NU;
    localparam int EW = DW + CW - FRAC + 1;

    // Frame table: mode, user, seed (99 = saturating pilot), idle gaps, mode toggling
    localparam int NV = 7;
    localparam int V_MODE [NV] = '{0, 1, 2, 3, 3, 1, 2};
    localparam int V_USER [NV] = '{0, 5, 3, 7, 1, 6, 2};
    localparam int V_SEED [NV] = '{1, 2, 3, 4, 5, 6, 99};
    localparam int V_GAPS [NV] = '{0, 0, 1, 0, 0, 1, 0};
    localparam int V_FLIP [NV] = '{0, 0, 0, 1, 0, 1, 0};

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_pilot = 0;
    logic [1:0] in_mode = 0;
    logic [2:0] in_user = 0;
    logic signed [DW-1:0] in_re = 0, in_im = 0;
    logic out_valid;
    logic [2:0] out_idx;
    logic signed [EW-1:0] out_re, out_im;

    int checks = 0, fails = 0;
    bit done = 0;
    longint mw_re [NSC];
    longint mw_im [NSC];

    always #2.5 clk = ~clk;

    pilot_eq_despread #(.DW(DW), .FRAC(FRAC), .CW(CW), .NSC(NSC), .NU(NU), .NOISE(NOISE)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pilot(in_pilot),
        .in_mode(in_mode), .in_user(in_user), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_idx(out_idx), .out_re(out_re), .out_im(out_im));

    function automatic int pil_re(int k, int s);
        if (s == 99) return (k % 2 == 0) ? 20 : 0;
        return ((k*29 + s*53) % 401) - 200;
    endfunction
    function automatic int pil_im(int k, int s);
        if (s == 99) return (k % 2 == 1) ? -20 : 0;
        return ((k*17 + s*71 + 100) % 401) - 200;
    endfunction
    function automatic int dat_re(int k, int n, int s);
        return ((k*41 + n*13 + s*7) % 601) - 300;
    endfunction
    function automatic int dat_im(int k, int n, int s);
        return ((k*23 + n*31 + s*19 + 50) % 601) - 300;
    endfunction

    function automatic longint clip(longint v);
        if (v > 4095) return 4095;
        if (v < -4096) return -4096;
        return v;
    endfunction

    task automatic model_coef(int mode, int k, longint hr, longint hi);
        longint ar, ai, mx, mn, den;
        ar = (hr < 0) ? -hr : hr;
        ai = (hi < 0) ? -hi : hi;
        mx = (ar > ai) ? ar : ai;
        mn = (ar > ai) ? ai : ar;
        case (mode)
            1: den = mx + (mn >>> 1);
            2: den = (hr*hr + hi*hi) >>> FRAC;
            3: den = ((hr*hr + hi*hi) >>> FRAC) + NOISE;
            default: den = 256;
        endcase
        if (den == 0) den = 1;
        mw_re[k] = clip((hr * 256) / den);
        mw_im[k] = clip((-hi * 256) / den);
    endtask

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(bit v, bit p, int re, int im, int mode, int user);
        @(negedge clk);
        in_valid = v; in_pilot = p;
        in_re = DW'(re); in_im = DW'(im);
        in_mode = 2'(mode); in_user = 3'(user);
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 0; in_pilot = 0;
    endtask

    task automatic pilot_sym(int s, int mode);
        for (int k = 0; k < NSC; k++) begin
            send(1, 1, pil_re(k, s), pil_im(k, s), mode, 0);
            model_coef(mode, k, pil_re(k, s), pil_im(k, s));
            if (k % NU == NU-1) begin
                @(posedge clk); #1;
                check("R11 pilot pulse", out_valid, 0);
            end
        end
    endtask

    task automatic data_sym(int n, int s, int user, bit gaps, bit flip, string tag);
        longint sr, si, er, ei, yr, yi;
        for (int k = 0; k < NSC; k++) begin
            if (gaps && (k % 5 == 2)) send(0, k % 2, 321, -211, k % 4, user);
            yr = dat_re(k, n, s);
            yi = dat_im(k, n, s);
            send(1, 0, int'(yr), int'(yi), flip ? (k % 4) : 0, user);
            if (k % NU == 0) begin sr = 0; si = 0; end
            er = (yr*mw_re[k] - yi*mw_im[k]) >>> FRAC;
            ei = (yr*mw_im[k] + yi*mw_re[k]) >>> FRAC;
            if ($countones(user & (k % NU)) % 2 == 1) begin er = -er; ei = -ei; end
            sr += er; si += ei;
            if (k % NU == NU-1) begin
                @(posedge clk); #1;
                check({tag, " R10 valid"}, out_valid, 1);
                check({tag, " R10 idx"}, out_idx, k / NU);
                check({tag, " R9 R10 re"}, longint'(out_re), sr >>> 3);
                check({tag, " R9 R10 im"}, longint'(out_im), si >>> 3);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        string mt;
        for (int k = 0; k < NSC; k++) begin mw_re[k] = 0; mw_im[k] = 0; end
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset valid", out_valid, 0);
        check("R1 reset re", longint'(out_re), 0);
        check("R1 reset idx", out_idx, 0);
        @(negedge clk); rst_n = 1;
        // R1: no pilot yet, coefficients are zero
        data_sym(0, 9, 3, 0, 0, "R1 pre-pilot");
        go_idle();

        // Table walk: each frame is a pilot then two data symbols
        for (int v = 0; v < NV; v++) begin
            case (V_MODE[v])
                0: mt = "R3";
                1: mt = "R4";
                2: mt = "R5";
                default: mt = "R6";
            endcase
            if (V_SEED[v] == 99) mt = {mt, " R7"};
            if (V_GAPS[v] != 0) mt = {mt, " R2"};
            if (V_FLIP[v] != 0) mt = {mt, " R8"};
            pilot_sym(V_SEED[v], V_MODE[v]);
            data_sym(0, V_SEED[v], V_USER[v], V_GAPS[v] != 0, V_FLIP[v] != 0, mt);
            data_sym(1, V_SEED[v], V_USER[v], V_GAPS[v] != 0, V_FLIP[v] != 0, {mt, " R8"});
            go_idle();
        end

        // R2: long idle stretch with garbage, then a data symbol stays aligned
        for (int i = 0; i < 7; i++) send(0, 1, -400, 400, 2, 5);
        go_idle();
        @(posedge clk); #1;
        check("R2 idle no pulse", out_valid, 0);
        data_sym(2, 2, 4, 0, 1, "R2 R8 after idle");
        go_idle();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule